// File: doc/BRIEF.md
# Multi-Channel Debounced Interrupt Detector

This block watches up to eight external input lines and turns a change of level into an interrupt only after the new level has stayed put for a programmable number of milliseconds. A free-running divider makes a one-millisecond tick from the slow reference clock. Each channel counts those ticks while its synchronized input differs from the last accepted level. When the count reaches the channel's hold time, the channel accepts the new level. If that level matches the channel's active polarity, the channel also raises its sticky status bit.

Software reaches the block through a small register port. This port is a write strobe, an address, write data and combinational read data. Through it software sets per-channel enables, polarities, interrupt masks and hold times. It can also read the status bits and the accepted levels, and write ones to clear status. Once a channel has fired, it stays quiet until its status is cleared. The single interrupt output is the masked OR of all status bits. A channel's counter only moves while it has an unresolved transition, so an idle channel's counting logic does no work.

Top module: `deb_irq_ctrl`

## Requirements
- R1: After reset every configuration register, every status bit, every accepted level and the interrupt output are 0.
- R2: With hold time T ms, a new input level is accepted on the (T+1)-th tick after the synchronized input first differs from the accepted level. A level held for less than T tick periods, and in particular less than one tick period, is never accepted.
- R3: A hold-time value of 0 behaves as 1 ms. A value above 4000 behaves as 4000 ms. The register reads back exactly what was written.
- R4: If the synchronized input returns to the accepted level before acceptance, the count restarts from zero.
- R5: The polarity bit selects the active level: 1 makes an accepted high an event, and 0 makes an accepted low an event. Accepting the other level updates the level register only.
- R6: The status bit of a channel is set by an event and stays set. Writing 1 to the matching bit of the clear register clears it and re-arms the channel. An input that stays at the accepted level after the clear raises nothing new.
- R7: The interrupt output equals the OR over channels of status AND mask.
- R8: The level register reports each channel's accepted level whatever the status and mask.
- R9: While a channel's enable bit is 0 it neither counts nor changes its accepted level nor sets status. On enabling, a pending difference is qualified normally.
- R10: A channel's counter is zero whenever it has no pending transition, and it changes only on tick cycles.
- R11: The register map is as follows. Address 0 holds enable, 1 polarity, 2 mask, 3 status (read-only), 4 clear (write-only, reads 0) and 5 accepted level (read-only), with bit i belonging to channel i. Address 8+i holds the 12-bit hold time of channel i. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | N_CH | Unsynchronized input lines, one per channel |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register address |
| wdata | input | 12 | Register write data |
| rdata | output | 12 | Combinational register read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions take three things for granted. First, the tick divider is set to at least two cycles, so ticks are never back to back. Second, a channel's status may only rise on a cycle that follows an enabled tick. Third, a status bit may only fall after a clear write. The stimulus keeps clear writes away from the cycles where an event is expected, and it changes the enable and hold-time registers only while the affected channel has no pending transition. Input pulses are driven on falling clock edges and are either clearly shorter or clearly longer than the qualification window, with a margin of several cycles for the synchronizer and the unknown tick phase.

// File: rtl/deb_pkg.sv
package deb_pkg;
    localparam int TIME_W = 12;
    localparam int REG_DW = 12;
    localparam int REG_AW = 4;
    localparam int MAX_MS = 4000;

    typedef enum logic [REG_AW-1:0] {
        RA_ENABLE = 4'd0,
        RA_POLAR  = 4'd1,
        RA_MASK   = 4'd2,
        RA_STATUS = 4'd3,
        RA_CLEAR  = 4'd4,
        RA_LEVEL  = 4'd5
    } reg_addr_e;

    // Effective hold time: zero means one millisecond, large values saturate.
    function automatic logic [TIME_W-1:0] clamp_ms(input logic [TIME_W-1:0] v);
        if (v == '0)
            return TIME_W'(1);
        else if (v > TIME_W'(MAX_MS))
            return TIME_W'(MAX_MS);
        else
            return v;
    endfunction
endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_t;

    tg_t tg_d, tg_q;

    always_comb begin
        tg_d      = tg_q;
        tg_d.tick = (tg_q.cnt == CW'(DIV - 1));
        if (tg_d.tick)
            tg_d.cnt = '0;
        else
            tg_d.cnt = tg_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tg_q <= '0;
        else
            tg_q <= tg_d;
    end

    assign tick = tg_q.tick;

    // Ticks are isolated pulses, so a channel counts at most once per period.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/deb_channel.sv
module deb_channel
    import deb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              pol,
    input  logic              clr,
    input  logic              raw,
    input  logic [TIME_W-1:0] tm,
    output logic              level,
    output logic              status
);
    typedef struct packed {
        logic              meta;
        logic              sync;
        logic              lvl;
        logic [TIME_W-1:0] cnt;
        logic              status;
    } ch_t;

    ch_t               ch_d, ch_q;
    logic              pending;
    logic              fire;
    logic [TIME_W-1:0] thr;

    always_comb begin
        ch_d      = ch_q;
        fire      = 1'b0;
        thr       = clamp_ms(tm);
        ch_d.meta = raw;
        ch_d.sync = ch_q.meta;
        pending   = en && (ch_q.sync != ch_q.lvl);
        if (!pending) begin
            // Idle or back at the accepted level: counter rests at zero.
            ch_d.cnt = '0;
        end else if (tick) begin
            if (ch_q.cnt >= thr) begin
                ch_d.lvl = ch_q.sync;
                ch_d.cnt = '0;
                fire     = (ch_q.sync == pol);
            end else begin
                ch_d.cnt = ch_q.cnt + 1'b1;
            end
        end
        if (clr)
            ch_d.status = 1'b0;
        if (fire)
            ch_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ch_q <= '0;
        else
            ch_q <= ch_d;
    end

    assign level  = ch_q.lvl;
    assign status = ch_q.status;

    assert_idle_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> (ch_q.cnt == '0));
    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tick) |=> $stable(ch_q.cnt));
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ch_q.lvl));
    assert_lvl_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_q.lvl) |-> $past(tick));
    assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_q.status) |-> $past(tick && en));
    assert_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_q.status) |-> $past(clr));
endmodule

// File: rtl/deb_irq_ctrl.sv
module deb_irq_ctrl
    import deb_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int TICK_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   raw_in,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    output logic              irq
);
    typedef struct packed {
        logic [N_CH-1:0]             en;
        logic [N_CH-1:0]             pol;
        logic [N_CH-1:0]             mask;
        logic [N_CH-1:0][TIME_W-1:0] tm;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic            tick;
    logic [N_CH-1:0] clr;
    logic [N_CH-1:0] lvl_v;
    logic [N_CH-1:0] stat_v;
    logic            tm_sel;

    assign tm_sel = addr[3] && (int'(addr[2:0]) < N_CH);

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (wr_en) begin
            case (addr)
                RA_ENABLE: cfg_d.en   = wdata[N_CH-1:0];
                RA_POLAR:  cfg_d.pol  = wdata[N_CH-1:0];
                RA_MASK:   cfg_d.mask = wdata[N_CH-1:0];
                RA_CLEAR:  clr        = wdata[N_CH-1:0];
                default: begin
                    if (tm_sel)
                        cfg_d.tm[addr[2:0]] = wdata[TIME_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    deb_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        deb_channel ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .en     (cfg_q.en[i]),
            .pol    (cfg_q.pol[i]),
            .clr    (clr[i]),
            .raw    (raw_in[i]),
            .tm     (cfg_q.tm[i]),
            .level  (lvl_v[i]),
            .status (stat_v[i])
        );
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_ENABLE: rdata[N_CH-1:0] = cfg_q.en;
            RA_POLAR:  rdata[N_CH-1:0] = cfg_q.pol;
            RA_MASK:   rdata[N_CH-1:0] = cfg_q.mask;
            RA_STATUS: rdata[N_CH-1:0] = stat_v;
            RA_LEVEL:  rdata[N_CH-1:0] = lvl_v;
            default: begin
                if (tm_sel)
                    rdata[TIME_W-1:0] = cfg_q.tm[addr[2:0]];
            end
        endcase
    end

    assign irq = |(stat_v & cfg_q.mask);

    // A clear write takes the cleared channels' status down unless a tick could fire them.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_CLEAR && !tick) |=> ((stat_v & $past(wdata[N_CH-1:0])) == '0));
endmodule

// File: tb/deb_irq_ctrl_tb_top.sv
module deb_irq_ctrl_tb_top;
    localparam int N  = 8;
    localparam int DV = 8;
    localparam int WD = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] raw_in;
    logic        wr_en;
    logic [3:0]  addr;
    logic [11:0] wdata;
    logic [11:0] rdata;
    logic        irq;
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;

    always #10 clk = ~clk;

    deb_irq_ctrl #(.N_CH(N), .TICK_DIV(DV)) dut_i (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // {channel[3], hold time[12], high cycles[16], expected status[1]}
    localparam logic [31:0] VECS [6] = '{
        {3'd0, 12'd1, 16'd5,  1'b0},
        {3'd1, 12'd1, 16'd30, 1'b1},
        {3'd2, 12'd3, 16'd20, 1'b0},
        {3'd0, 12'd3, 16'd40, 1'b1},
        {3'd1, 12'd0, 16'd20, 1'b1},
        {3'd2, 12'd0, 16'd6,  1'b0}
    };

    task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [11:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD);
            finish_run();
        end
    end

    initial begin
        logic [11:0] v;
        raw_in = '0; wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 12'h0);
        end
        chk("R1", "irq after reset", {11'd0, irq}, 12'h0);

        // R11: map and read-back
        wr(4'd0, 12'h0A5); rd(4'd0, v); chk("R11", "enable readback", v, 12'h0A5);
        wr(4'd9, 12'h123); rd(4'd9, v); chk("R11", "time 1 readback", v, 12'h123);
        wr(4'd4, 12'h0FF); rd(4'd4, v); chk("R11", "clear reads zero", v, 12'h0);
        rd(4'd6, v); chk("R11", "unused address", v, 12'h0);

        wr(4'd0, 12'h0FF); wr(4'd1, 12'h0FF); wr(4'd2, 12'h0FF);

        // Table walk: R2 window, R3 zero value
        for (int k = 0; k < 6; k++) begin
            logic [2:0]  ch;
            logic [11:0] th;
            logic [15:0] hold;
            logic        ex;
            int          eff;
            ch   = VECS[k][31:29];
            th   = VECS[k][28:17];
            hold = VECS[k][16:1];
            ex   = VECS[k][0];
            eff  = (th == 0) ? 1 : int'(th);
            wr({1'b1, ch}, th);
            raw_in[ch] = 1'b1;
            waitc(int'(hold));
            raw_in[ch] = 1'b0;
            waitc((eff + 2) * DV + 6);
            rd(4'd3, v);
            chk((th == 0) ? "R3" : "R2", $sformatf("vector %0d status", k), {11'd0, v[ch]}, {11'd0, ex});
            chk("R7", $sformatf("vector %0d irq", k), {11'd0, irq}, {11'd0, ex});
            rd(4'd5, v);
            chk("R2", $sformatf("vector %0d level back low", k), {11'd0, v[ch]}, 12'h0);
            wr(4'd4, 12'h0FF);
        end

        // R2 exact window, R8, R7, R6 on channel 4 with 2 ms
        wr(4'd12, 12'd2);
        raw_in[4] = 1'b1;
        waitc(2 * DV - 1);
        rd(4'd3, v); chk("R2", "not yet accepted", {11'd0, v[4]}, 12'h0);
        waitc(DV + 5);
        rd(4'd3, v); chk("R2", "accepted by window end", {11'd0, v[4]}, 12'h1);
        rd(4'd5, v); chk("R8", "level high", {11'd0, v[4]}, 12'h1);
        wr(4'd2, 12'h000);
        chk("R7", "masked irq", {11'd0, irq}, 12'h0);
        rd(4'd5, v); chk("R8", "level independent of mask", {11'd0, v[4]}, 12'h1);
        wr(4'd2, 12'h0FF);
        chk("R7", "unmasked irq", {11'd0, irq}, 12'h1);
        wr(4'd4, 12'h010);
        rd(4'd3, v); chk("R6", "cleared", {11'd0, v[4]}, 12'h0);
        waitc(40);
        rd(4'd3, v); chk("R6", "held input no refire", {11'd0, v[4]}, 12'h0);
        raw_in[4] = 1'b0; waitc(40);
        rd(4'd3, v); chk("R6", "inactive level no event", {11'd0, v[4]}, 12'h0);
        raw_in[4] = 1'b1; waitc(40);
        rd(4'd3, v); chk("R6", "re-armed event", {11'd0, v[4]}, 12'h1);
        raw_in[4] = 1'b0; waitc(40);
        rd(4'd3, v); chk("R6", "sticky after return", {11'd0, v[4]}, 12'h1);
        wr(4'd4, 12'h010);

        // R5: active-low channel 5
        wr(4'd13, 12'd1);
        wr(4'd1, 12'h0DF);
        raw_in[5] = 1'b1; waitc(30);
        rd(4'd3, v); chk("R5", "high not an event", {11'd0, v[5]}, 12'h0);
        rd(4'd5, v); chk("R5", "level high", {11'd0, v[5]}, 12'h1);
        raw_in[5] = 1'b0; waitc(30);
        rd(4'd3, v); chk("R5", "low is event", {11'd0, v[5]}, 12'h1);
        rd(4'd5, v); chk("R5", "level low", {11'd0, v[5]}, 12'h0);
        wr(4'd4, 12'h020);
        wr(4'd1, 12'h0FF);

        // R4: interrupted runs restart the count, channel 6 with 3 ms
        wr(4'd14, 12'd3);
        raw_in[6] = 1'b1; waitc(20);
        raw_in[6] = 1'b0; waitc(3);
        raw_in[6] = 1'b1; waitc(20);
        raw_in[6] = 1'b0; waitc(40);
        rd(4'd3, v); chk("R4", "split pulse no event", {11'd0, v[6]}, 12'h0);
        rd(4'd5, v); chk("R4", "split pulse level", {11'd0, v[6]}, 12'h0);

        // R9: disabled channel 3
        wr(4'd11, 12'd1);
        wr(4'd0, 12'h0F7);
        raw_in[3] = 1'b1; waitc(40);
        rd(4'd3, v); chk("R9", "disabled no status", {11'd0, v[3]}, 12'h0);
        rd(4'd5, v); chk("R9", "disabled level frozen", {11'd0, v[3]}, 12'h0);
        wr(4'd0, 12'h0FF);
        waitc(40);
        rd(4'd3, v); chk("R9", "enabled qualifies", {11'd0, v[3]}, 12'h1);
        raw_in[3] = 1'b0; waitc(40);
        wr(4'd4, 12'h008);

        // R10: counter gating visible as no spurious events across idle time
        waitc(100);
        rd(4'd3, v); chk("R10", "idle channels quiet", v, 12'h0);

        // R3: saturation of 4095 to 4000 on channel 7
        wr(4'd15, 12'hFFF);
        raw_in[7] = 1'b1;
        waitc(4000 * DV - 2);
        rd(4'd3, v); chk("R3", "saturated not early", {11'd0, v[7]}, 12'h0);
        waitc(DV + 6);
        rd(4'd3, v); chk("R3", "saturated fires at 4000", {11'd0, v[7]}, 12'h1);
        rd(4'd15, v); chk("R3", "raw value kept", v, 12'hFFF);

        finish_run();
    end
endmodule